// File: doc/BRIEF.md
# Output Impedance Calibration Controller

This block keeps the strength code of an output driver close to its best value while supply voltage and temperature drift. A free-running period timer starts an evaluation at fixed intervals. During an evaluation the controller samples two comparison flags from an analog sense path outside the block. It then moves the impedance code up one step, down one step, or leaves it where it is. Because the code can only move one step per evaluation, it reaches a new target gradually and never jumps. Resistor sensing, the comparator and the driver legs are outside the block.

A separate warm-up counter starts at reset. It counts clock cycles whether or not evaluations are enabled, and it raises the ready flag once the start-up interval has elapsed. Evaluations also run during warm-up, so the code is already near its target when ready asserts. The code is a plain binary value: bit k switches in a driver leg of relative strength 2^k.

The block contains two small state machines:

- **Evaluation sequencer.**
  - It has two states, `ST_WAIT` and `ST_EVAL`.
  - Transition `ST_WAIT -> ST_EVAL` is taken on a period tick.
  - Transition `ST_EVAL -> ST_WAIT` is always taken after one cycle.
  - The code register updates on the edge that leaves `ST_EVAL`.
- **Warm-up gate.**
  - It has two states, `SU_WARMUP` and `SU_SETTLED`.
  - Transition `SU_WARMUP -> SU_SETTLED` is taken when the warm-up count reaches its end.
  - `SU_SETTLED` has no exit other than reset.

Top module: `imp_cal_ctrl`

## Requirements
- R1: While `rst_n` is low, `imp_code` is mid-scale (6'b100000 = 32), and `eval_strobe` and `cal_ready` are 0.
- R2: While `cal_en` is high, `eval_strobe` is high for exactly one cycle every `PERIOD` clock edges. The first strobe is visible after edge `PERIOD` counted from reset release.
- R3: While `cal_en` is low, the period timer holds its count and no strobe occurs. After `cal_en` returns high, the next strobe comes after `PERIOD` edges less those already counted. The code does not change during the pause, even with a compare flag raised.
- R4: If at an evaluation `cmp_high`=1 and `cmp_low`=0, the code increases by exactly 1. If `cmp_low`=1 and `cmp_high`=0, it decreases by exactly 1. The new value is visible in the cycle after the strobe.
- R5: If at an evaluation both flags are 0, or both are 1, the code holds its value.
- R6: The code saturates at 63 and at 0 and never wraps.
- R7: The code changes only on the edge that ends a strobe cycle, and by at most one step.
- R8: `cal_ready` rises exactly `STARTUP` (32768) edges after reset release, whatever the state of `cal_en`, and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_en | input | 1 | Enables the period timer |
| cmp_high | input | 1 | Sense path requests a stronger driver (code up) |
| cmp_low | input | 1 | Sense path requests a weaker driver (code down) |
| imp_code | output | CODE_W (6) | Binary-weighted impedance code |
| eval_strobe | output | 1 | High for the one cycle in which an evaluation samples the flags |
| cal_ready | output | 1 | Start-up interval has elapsed |

## Verification
The hardest states to reach from the ports are the two saturation limits. Reaching either one from mid-scale takes more than thirty successive evaluations, each a full period apart. The bench therefore shortens `PERIOD` to 16 and holds one compare flag across many strobes. It then keeps the flag asserted for extra strobes after the limit to show that the code does not wrap. The warm-up count stays at its full 32768 cycles. The earlier pause test toggles `cal_en`, which shows that the ready rise does not depend on enable.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

    // Evaluation sequencer states
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_EVAL = 1'b1
    } eval_state_e;

    // Warm-up gate states
    typedef enum logic {
        SU_WARMUP  = 1'b0,
        SU_SETTLED = 1'b1
    } warm_state_e;

    // Direction requested by the sense path
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

    function automatic step_dir_e decode_dir(input logic hi, input logic lo);
        step_dir_e d;
        unique case ({hi, lo})
            2'b10:   d = DIR_UP;
            2'b01:   d = DIR_DOWN;
            default: d = DIR_HOLD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/imp_period_timer.sv
module imp_period_timer #(
    parameter int PERIOD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tick = run && (cnt_q == LAST);
    end

    // R3
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));

    // R2
    timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/imp_startup_gate.sv
module imp_startup_gate
    import imp_cal_pkg::*;
#(
    parameter int STARTUP = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int SU_W = (STARTUP > 2) ? $clog2(STARTUP) : 1;
    localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP - 1);

    warm_state_e      state_q, state_d;
    logic [SU_W-1:0]  cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SU_WARMUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SU_WARMUP:  if (cnt_q == SU_LAST) state_d = SU_SETTLED;
            SU_SETTLED: state_d = SU_SETTLED;
            default:    state_d = SU_WARMUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q == SU_WARMUP) cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        ready = (state_q == SU_SETTLED);
    end

    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R8
    warm_count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SU_SETTLED) |=> $stable(cnt_q));

endmodule

// File: rtl/imp_code_stepper.sv
module imp_code_stepper
    import imp_cal_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmp_high,
    input  logic              cmp_low,
    output logic [CODE_W-1:0] code,
    output logic              eval
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

    eval_state_e       state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    step_dir_e         dir;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (tick) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    // code update, only while evaluating
    always_comb begin
        dir    = decode_dir(cmp_high, cmp_low);
        code_d = code_q;
        if (state_q == ST_EVAL) begin
            unique case (dir)
                DIR_UP:   if (code_q != CODE_MAX) code_d = code_q + 1'b1;
                DIR_DOWN: if (code_q != CODE_MIN) code_d = code_q - 1'b1;
                default:  code_d = code_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= CODE_MID;
        else        code_q <= code_d;
    end

    // outputs
    always_comb begin
        eval = (state_q == ST_EVAL);
        code = code_q;
    end

    // R7
    code_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(code_q));

    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> ((code_q == $past(code_q)) ||
                  (code_q == $past(code_q) + 1'b1) ||
                  (code_q == $past(code_q) - 1'b1)));

    // R5
    hold_when_ambiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && (cmp_high == cmp_low)) |=> $stable(code_q));

    // R6
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && cmp_high && !cmp_low && code_q == CODE_MAX) |=> (code_q == CODE_MAX));

    // R6
    no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && cmp_low && !cmp_high && code_q == CODE_MIN) |=> (code_q == CODE_MIN));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> !eval);

    // R2
    no_tick_in_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval |-> !tick);

endmodule

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl #(
    parameter int CODE_W  = 6,
    parameter int PERIOD  = 1024,
    parameter int STARTUP = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_en,
    input  logic              cmp_high,
    input  logic              cmp_low,
    output logic [CODE_W-1:0] imp_code,
    output logic              eval_strobe,
    output logic              cal_ready
);
    logic period_tick;

    imp_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cal_en),
        .tick  (period_tick)
    );

    imp_code_stepper #(.CODE_W(CODE_W)) u_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (period_tick),
        .cmp_high (cmp_high),
        .cmp_low  (cmp_low),
        .code     (imp_code),
        .eval     (eval_strobe)
    );

    imp_startup_gate #(.STARTUP(STARTUP)) u_warmup (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (cal_ready)
    );

    // R3
    no_strobe_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> !eval_strobe);

endmodule

// File: tb/test_imp_cal_ctrl.sv
module test_imp_cal_ctrl;
    localparam int CW = 6;
    localparam int P  = 16;
    localparam int SU = 32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_en = 1'b1;
    logic cmp_high = 1'b0;
    logic cmp_low = 1'b0;
    logic [CW-1:0] imp_code;
    logic eval_strobe;
    logic cal_ready;

    int checks = 0;
    int errors = 0;
    int edges = 0;
    int ready_rise = -1;
    logic prev_strobe = 1'b0;
    logic [CW-1:0] prev_code = '0;
    logic mon_on = 1'b0;

    always #4 clk = ~clk;

    imp_cal_ctrl #(.CODE_W(CW), .PERIOD(P), .STARTUP(SU)) i_imp_cal_ctrl (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en),
        .cmp_high(cmp_high), .cmp_low(cmp_low),
        .imp_code(imp_code), .eval_strobe(eval_strobe), .cal_ready(cal_ready)
    );

    always @(posedge clk) if (rst_n) edges++;

    // R7 / R8 monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (imp_code != prev_code) begin
                if (!prev_strobe) begin
                    errors++;
                    $display("FAIL R7: code moved %0d->%0d without strobe", prev_code, imp_code);
                end
                if ((imp_code - prev_code != 1) && (prev_code - imp_code != 1)) begin
                    errors++;
                    $display("FAIL R7: step %0d->%0d larger than one", prev_code, imp_code);
                end
            end
            if (cal_ready && ready_rise < 0) ready_rise = edges;
            if (!cal_ready && ready_rise >= 0) begin
                errors++;
                $display("FAIL R8: ready dropped actual 0 expected 1");
            end
        end
        prev_code   = imp_code;
        prev_strobe = eval_strobe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic wait_strobe(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!eval_strobe && waited < 4000);
    endtask

    task automatic test_reset();
        repeat (4) @(negedge clk);
        check(imp_code == 6'd32, "R1 code", imp_code, 32);
        check(eval_strobe == 1'b0, "R1 strobe", eval_strobe, 0);
        check(cal_ready == 1'b0, "R1 ready", cal_ready, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic test_period();
        int w;
        wait_strobe(w);
        check(edges == P, "R2 first strobe edge", edges, P);
        check(imp_code == 6'd32, "R5 code before", imp_code, 32);
        @(negedge clk);
        check(eval_strobe == 1'b0, "R2 strobe width", eval_strobe, 0);
        check(imp_code == 6'd32, "R5 neither flag holds", imp_code, 32);
        wait_strobe(w);
        check(w == P - 1, "R2 spacing", w + 1, P);
        check(cal_ready == 1'b0, "R8 not ready early", cal_ready, 0);
    endtask

    task automatic test_step(input bit hi, input bit lo, input int delta, input string req);
        int w;
        int c0;
        @(negedge clk);
        cmp_high = hi;
        cmp_low  = lo;
        wait_strobe(w);
        c0 = imp_code;
        @(negedge clk);
        check(imp_code == CW'(c0 + delta), req, imp_code, c0 + delta);
        cmp_high = 1'b0;
        cmp_low  = 1'b0;
    endtask

    task automatic test_enable();
        int w;
        int c0;
        bit seen;
        wait_strobe(w);
        cal_en = 1'b0;
        @(negedge clk);
        c0 = imp_code;
        cmp_high = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (eval_strobe) seen = 1'b1;
        end
        check(!seen, "R3 no strobe while off", seen, 0);
        check(imp_code == CW'(c0), "R3 code frozen", imp_code, c0);
        cal_en = 1'b1;
        wait_strobe(w);
        check(w == P, "R3 resume spacing", w, P);
        @(negedge clk);
        check(imp_code == CW'(c0 + 1), "R3 step after resume", imp_code, c0 + 1);
        cmp_high = 1'b0;
    endtask

    task automatic test_saturate(input bit up);
        int w;
        int lim;
        int exp_c;
        lim = up ? 63 : 0;
        cmp_high = up;
        cmp_low  = !up;
        for (int i = 0; i < 70; i++) begin
            exp_c = up ? ((imp_code == 63) ? 63 : imp_code + 1)
                       : ((imp_code == 0) ? 0 : imp_code - 1);
            wait_strobe(w);
            @(negedge clk);
            if (imp_code != CW'(exp_c)) begin
                check(1'b0, "R4 walk", imp_code, exp_c);
            end
            if (imp_code == CW'(lim) && i > 64) break;
        end
        check(imp_code == CW'(lim), up ? "R6 top limit" : "R6 bottom limit", imp_code, lim);
        for (int i = 0; i < 3; i++) begin
            wait_strobe(w);
            @(negedge clk);
            check(imp_code == CW'(lim), "R6 no wrap", imp_code, lim);
        end
        cmp_high = 1'b0;
        cmp_low  = 1'b0;
    endtask

    task automatic test_ready();
        int n;
        n = 0;
        while (ready_rise < 0 && n < 40000) begin
            @(negedge clk);
            n++;
        end
        check(ready_rise == SU, "R8 ready rise", ready_rise, SU);
        repeat (5) @(negedge clk);
        check(cal_ready == 1'b1, "R8 ready stays", cal_ready, 1);
    endtask

    initial begin
        test_reset();
        test_period();
        test_step(1'b1, 1'b0, 1, "R4 up");
        test_step(1'b0, 1'b1, -1, "R4 down");
        test_step(1'b1, 1'b1, 0, "R5 both flags hold");
        test_enable();
        test_saturate(1'b1);
        test_saturate(1'b0);
        test_ready();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule